// File: doc/BRIEF.md
# Bus remote wake-up detector

This block watches the digitized receive level of a single-wire bus and decides when a remote node has asked the local device to wake. A wake-up counts only when the bus falls from recessive to dominant and stays dominant for a programmable minimum number of clock cycles. The bus must then return to recessive. The rising edge that ends a long enough dominant period confirms the wake-up. A dominant level that is held and never released does not confirm anything.

The bus level goes through a two-flop synchronizer before edges are taken from it. A saturating counter measures the dominant time. Measurement runs in Sleep and Standby. In Normal it runs only while the transmit-data level is recessive (HIGH), and if that level drops, the current measurement is abandoned. A confirmed wake-up gives a one-cycle pulse and sets a latched request. In Standby the host sees that request as RXD held LOW. In Sleep the RXD pin is undriven, which is shown here by a separate drive-enable output. The design is split into a control FSM and a datapath, joined by a small strobe struct, under a thin top.

Top module: `bus_wake_detect`

## Requirements
- R1: Once reset is released, the latched request is clear and wakePulse is 0. In Standby, rxdLevel is 1 and rxdDriveEn is 1.
- R2: busRx uses 1 for recessive and 0 for dominant. A dominant run of at least MIN_DOM_CYCLES clock samples, however long, followed by a return to recessive produces exactly one wakePulse that lasts one cycle. That pulse is high in the cycle after the third rising clock edge following the return of busRx to 1.
- R3: A dominant run of MIN_DOM_CYCLES-1 samples produces no wakePulse. A single recessive sample inside a run restarts the measurement, so two short runs split by one recessive sample produce no wakePulse.
- R4: While the bus stays dominant, no wakePulse occurs and no request is latched, however long the dominant period lasts.
- R5: modeSel uses 2'b00 for Sleep, 2'b01 for Standby, 2'b10 for Normal and 2'b11 for a code that acts as Sleep. In Normal, the dominant time is measured only while txdLevel is 1. If txdLevel is 0 at the falling edge, or goes to 0 at any point during the run, that run produces no wakePulse.
- R6: A confirmed wake-up in Sleep or Standby sets the latched request. From then on, rxdLevel stays 0 in Standby, and this also holds after a switch from Sleep to Standby.
- R7: In Sleep, and with modeSel 2'b11, rxdDriveEn is 0.
- R8: The latched request is cleared by a one-cycle wakeClear or by any cycle spent in Normal. When a confirmation and wakeClear fall in the same cycle, the request stays set.
- R9: In Normal, rxdDriveEn is 1 and rxdLevel follows busRx with a delay of two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busRx | input | 1 | Bus comparator output, 1 = recessive, 0 = dominant |
| txdLevel | input | 1 | Transmit-data level from the host, 1 = recessive |
| modeSel | input | 2 | Operating mode: 00 Sleep, 01 Standby, 10 Normal, 11 acts as Sleep |
| wakeClear | input | 1 | Clears the latched wake request |
| wakePulse | output | 1 | One-cycle pulse for each confirmed wake-up |
| rxdLevel | output | 1 | Level driven toward the host on RXD |
| rxdDriveEn | output | 1 | 1 when RXD is driven, 0 when undriven (Sleep) |

## Verification
Confirming a wake-up sets the latched request, and wakeClear clears it, so the two can act on the latch in the same clock cycle. The bench provokes this by ending a qualified dominant run and then asserting wakeClear for exactly the cycle in which the confirmation strobe is live, two falling clock edges after busRx returns high. The result is judged at the ports. The scoreboard must see one wakePulse, and rxdLevel in Standby must stay 0 afterwards, which shows that the set won. A later wakeClear on its own must then bring rxdLevel back to 1.

// File: rtl/wake_pkg.sv
package wake_pkg;

  typedef enum logic [1:0] {
    MODE_SLEEP   = 2'b00,
    MODE_STANDBY = 2'b01,
    MODE_NORMAL  = 2'b10,
    MODE_PARK    = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    ST_IDLE      = 2'b00,
    ST_MEASURE   = 2'b01,
    ST_QUALIFIED = 2'b10
  } wake_state_e;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic cntStart;   // first dominant sample: counter to one
    logic cntStep;    // further dominant sample: saturating increment
    logic cntDrop;    // measurement ends: counter to zero
    logic confirm;    // qualified run ended by recessive edge
  } wake_strobe_t;

endpackage

// File: rtl/wake_control.sv
module wake_control
  import wake_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  mode_e        mode,
  input  logic         txdLevel,
  input  logic         busFall,
  input  logic         busRise,
  input  logic         cntAtMin,
  output wake_strobe_t strb
);

  wake_state_e state, stateNext;
  logic        measEn;

  // measurement window: always in low-power modes, TXD-gated in Normal
  always_comb begin
    unique case (mode)
      MODE_NORMAL: measEn = txdLevel;
      default:     measEn = 1'b1;
    endcase
  end

  always_comb begin
    stateNext = state;
    strb      = '0;
    unique case (state)
      ST_IDLE: begin
        if (busFall && measEn) begin
          strb.cntStart = 1'b1;
          stateNext     = ST_MEASURE;
        end
      end
      ST_MEASURE: begin
        if (!measEn) begin
          strb.cntDrop = 1'b1;
          stateNext    = ST_IDLE;
        end else if (busRise) begin
          strb.confirm = cntAtMin;
          strb.cntDrop = 1'b1;
          stateNext    = ST_IDLE;
        end else begin
          strb.cntStep = 1'b1;
          if (cntAtMin) stateNext = ST_QUALIFIED;
        end
      end
      ST_QUALIFIED: begin
        if (!measEn) begin
          strb.cntDrop = 1'b1;
          stateNext    = ST_IDLE;
        end else if (busRise) begin
          strb.confirm = 1'b1;
          strb.cntDrop = 1'b1;
          stateNext    = ST_IDLE;
        end
      end
      default: begin
        strb.cntDrop = 1'b1;
        stateNext    = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  // R5: losing the measurement window always returns to idle
  a_r5_abandon_window: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && !measEn) |=> (state == ST_IDLE));

  // R3: no confirmation unless the datapath reports a full-length run
  a_r3_confirm_needs_min: assert property (@(posedge clk) disable iff (!rstN)
    strb.confirm |-> cntAtMin);

endmodule

// File: rtl/wake_datapath.sv
module wake_datapath
  import wake_pkg::*;
#(
  parameter int MIN_DOM_CYCLES = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         busRx,
  input  mode_e        mode,
  input  logic         wakeClear,
  input  wake_strobe_t strb,
  output logic         busFall,
  output logic         busRise,
  output logic         cntAtMin,
  output logic         wakePulse,
  output logic         rxdLevel,
  output logic         rxdDriveEn
);

  localparam int CNT_W = $clog2(MIN_DOM_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_DOM_CYCLES);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   busSync;
  logic                   busPrev;
  logic [CNT_W-1:0]       domCount;
  logic                   wakeLatched;

  // two-flop synchronizer, reset to recessive
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncChain <= '1;
    else       syncChain <= {syncChain[SYNC_STAGES-2:0], busRx};
  end
  assign busSync = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busPrev <= 1'b1;
    else       busPrev <= busSync;
  end

  assign busFall = busPrev && !busSync;
  assign busRise = !busPrev && busSync;

  // saturating dominant-time counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                  domCount <= '0;
    else if (strb.cntDrop)                      domCount <= '0;
    else if (strb.cntStart)                     domCount <= CNT_W'(1);
    else if (strb.cntStep && domCount < CNT_MAX) domCount <= domCount + CNT_W'(1);
  end
  assign cntAtMin = (domCount == CNT_MAX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wakePulse <= 1'b0;
    else       wakePulse <= strb.confirm;
  end

  // request latch: Normal clears first, a new wake beats an explicit clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    wakeLatched <= 1'b0;
    else if (mode == MODE_NORMAL) wakeLatched <= 1'b0;
    else if (strb.confirm)        wakeLatched <= 1'b1;
    else if (wakeClear)           wakeLatched <= 1'b0;
  end

  always_comb begin
    unique case (mode)
      MODE_STANDBY: begin
        rxdDriveEn = 1'b1;
        rxdLevel   = !wakeLatched;
      end
      MODE_NORMAL: begin
        rxdDriveEn = 1'b1;
        rxdLevel   = busSync;
      end
      default: begin
        rxdDriveEn = 1'b0;
        rxdLevel   = 1'b1;
      end
    endcase
  end

  // R2: each wake-up pulse is a single cycle
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |=> !wakePulse);

  // R2: the dominant counter saturates and never passes the limit
  a_r2_cnt_bounded: assert property (@(posedge clk) disable iff (!rstN)
    domCount <= CNT_MAX);

  // R6: the request is only ever raised together with a wake-up pulse
  a_r6_latch_source: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wakeLatched) |-> wakePulse);

  // R8: a cycle in Normal leaves no request behind
  a_r8_normal_clears: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_NORMAL) |=> !wakeLatched);

endmodule

// File: rtl/bus_wake_detect.sv
module bus_wake_detect
  import wake_pkg::*;
#(
  parameter int MIN_DOM_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busRx,
  input  logic       txdLevel,
  input  logic [1:0] modeSel,
  input  logic       wakeClear,
  output logic       wakePulse,
  output logic       rxdLevel,
  output logic       rxdDriveEn
);

  mode_e        mode;
  wake_strobe_t strb;
  logic         busFall;
  logic         busRise;
  logic         cntAtMin;

  assign mode = mode_e'(modeSel);

  wake_control u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .mode     (mode),
    .txdLevel (txdLevel),
    .busFall  (busFall),
    .busRise  (busRise),
    .cntAtMin (cntAtMin),
    .strb     (strb)
  );

  wake_datapath #(
    .MIN_DOM_CYCLES (MIN_DOM_CYCLES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .busRx      (busRx),
    .mode       (mode),
    .wakeClear  (wakeClear),
    .strb       (strb),
    .busFall    (busFall),
    .busRise    (busRise),
    .cntAtMin   (cntAtMin),
    .wakePulse  (wakePulse),
    .rxdLevel   (rxdLevel),
    .rxdDriveEn (rxdDriveEn)
  );

endmodule

// File: tb/bus_wake_detect_tb.sv
`timescale 1ns/1ps
module bus_wake_detect_tb;

  localparam int MIN = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busRx = 1'b1;
  logic       txdLevel = 1'b1;
  logic [1:0] modeSel = 2'b01;
  logic       wakeClear = 1'b0;
  logic       wakePulse, rxdLevel, rxdDriveEn;

  int    checks = 0;
  int    fails = 0;
  int    pulsesSeen = 0;
  bit    prevPulse = 1'b0;
  bit    done = 1'b0;
  int    expQ[$];
  string tagQ[$];

  always #4 clk = ~clk;

  bus_wake_detect #(.MIN_DOM_CYCLES(MIN)) u_dut (
    .clk(clk), .rstN(rstN), .busRx(busRx), .txdLevel(txdLevel),
    .modeSel(modeSel), .wakeClear(wakeClear), .wakePulse(wakePulse),
    .rxdLevel(rxdLevel), .rxdDriveEn(rxdDriveEn)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  // driver side of the scoreboard: expected pulse count for last stimulus
  task automatic expectWakes(string tag, int n);
    tick(8);
    expQ.push_back(n);
    tagQ.push_back(tag);
    tick(2);
  endtask

  task automatic domRun(int len);
    busRx = 1'b0;
    tick(len);
    busRx = 1'b1;
  endtask

  // monitor: counts pulses, checks width, pops expectations
  always @(negedge clk) begin
    if (rstN) begin
      if (wakePulse && prevPulse) begin
        checks++;
        fails++;
        $display("FAIL R2 pulse width actual=2 expected=1");
      end
      prevPulse = wakePulse;
      if (wakePulse) pulsesSeen++;
      if (expQ.size() > 0) begin
        int    e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(t, pulsesSeen, e);
        pulsesSeen = 0;
      end
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    tick(4);
    rstN = 1'b1;
    tick(2);
    check("R1 pulse after reset", wakePulse, 0);
    check("R1 rxd after reset", rxdLevel, 1);
    check("R1 drive after reset", rxdDriveEn, 1);

    domRun(MIN - 1);
    expectWakes("R3 short run", 0);
    check("R3 rxd after short run", rxdLevel, 1);

    busRx = 1'b0; tick(10); busRx = 1'b1; tick(1); domRun(10);
    expectWakes("R3 interrupted run", 0);

    // exact minimum run with pulse timing
    domRun(MIN);
    tick(2);
    check("R2 pulse not yet", wakePulse, 0);
    tick(1);
    check("R2 pulse on third edge", wakePulse, 1);
    tick(1);
    check("R2 pulse one cycle", wakePulse, 0);
    expectWakes("R2 exact minimum", 1);
    tick(20);
    check("R6 rxd held low", rxdLevel, 0);

    wakeClear = 1'b1; tick(1); wakeClear = 1'b0; tick(1);
    check("R8 clear releases rxd", rxdLevel, 1);

    domRun(3 * MIN);
    expectWakes("R2 long run saturates", 1);
    wakeClear = 1'b1; tick(1); wakeClear = 1'b0; tick(1);

    busRx = 1'b0;
    tick(5 * MIN);
    expectWakes("R4 held dominant", 0);
    check("R4 no latch while dominant", rxdLevel, 1);
    busRx = 1'b1;
    expectWakes("R2 release after hold", 1);
    wakeClear = 1'b1; tick(1); wakeClear = 1'b0; tick(1);

    modeSel = 2'b00; tick(1);
    check("R7 sleep undriven", rxdDriveEn, 0);
    domRun(MIN + 2);
    expectWakes("R6 wake in sleep", 1);
    modeSel = 2'b01; tick(1);
    check("R6 sleep wake seen in standby", rxdLevel, 0);
    check("R6 standby driven", rxdDriveEn, 1);
    modeSel = 2'b11; tick(1);
    check("R7 code 11 undriven", rxdDriveEn, 0);

    modeSel = 2'b10; tick(2);
    modeSel = 2'b01; tick(1);
    check("R8 normal clears request", rxdLevel, 1);

    modeSel = 2'b10; tick(1);
    check("R9 normal driven", rxdDriveEn, 1);
    busRx = 1'b0;
    tick(1);
    check("R9 rxd one edge", rxdLevel, 1);
    tick(1);
    check("R9 rxd two edges", rxdLevel, 0);
    busRx = 1'b1;
    tick(3);
    check("R9 rxd back high", rxdLevel, 1);
    expectWakes("R9 short run in normal", 0);

    domRun(MIN + 2);
    expectWakes("R5 normal txd high wakes", 1);
    modeSel = 2'b01; tick(1);
    check("R8 no request kept from normal", rxdLevel, 1);

    modeSel = 2'b10;
    busRx = 1'b0; tick(MIN / 2);
    txdLevel = 1'b0; tick(1); txdLevel = 1'b1;
    tick(2 * MIN); busRx = 1'b1;
    expectWakes("R5 txd low mid run", 0);

    txdLevel = 1'b0;
    domRun(MIN + 4);
    expectWakes("R5 txd low at fall", 0);
    txdLevel = 1'b1;

    // coincident confirm and clear
    modeSel = 2'b01; tick(2);
    domRun(MIN);
    tick(2);
    wakeClear = 1'b1;
    tick(1);
    wakeClear = 1'b0;
    check("R8 pulse with clear", wakePulse, 1);
    tick(2);
    check("R8 set wins over clear", rxdLevel, 0);
    expectWakes("R8 coincident wake", 1);
    wakeClear = 1'b1; tick(1); wakeClear = 1'b0; tick(1);
    check("R8 later clear", rxdLevel, 1);

    wait (expQ.size() == 0);
    tick(2);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule